// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index pulse of an incremental rotary or linear encoder into a 32-bit position count and a direction bit. The raw pins are first brought into the clock domain. They are then sampled at a rate set by a power-of-two prescaler and passed through a run-length glitch filter. The filtered phases are decoded into up and down steps at one, two or four counts per electrical cycle. The two phases can be exchanged to reverse the direction sense.

Around the counter sit the event sources a motion controller needs:
- reload of the count from a programmable start value on the index pulse, or when the count passes a programmable ceiling;
- a compare match;
- a snapshot of the count on every index pulse;
- a snapshot on an external strobe, taken after a programmable number of clocks.

Seven event flags feed one interrupt line through an enable mask. All configuration arrives on plain ports, so an outer register file can drive them directly.

Top module: `quad_counter`

## Requirements
- R1: After reset, position, dir, idx_snap, cap_snap and flags are all zero and irq is low.
- R2: With mul_sel = 2 (x4), each single-phase transition of the filtered (A,B) pair changes position by one. The sequence 00→10→11→01→00 counts up and the reverse sequence counts down. dir reads 1 after an up step and 0 after a down step.
- R3: With mul_sel = 1 (x2), only transitions of A change the count, giving two counts per full cycle. Transitions of B alone leave position unchanged.
- R4: With mul_sel = 0 (x1), only a rising edge of A counts. The count goes up when B is low and down when B is high, giving one count per full cycle.
- R5: With swap_ab = 1, A and B exchange roles, so the forward sequence counts down.
- R6: When both filtered phases change in the same sample, flags bit 1 (phase error) is raised and position is left unchanged.
- R7: A filtered input takes a new value only after filt_len+1 consecutive samples that all agree with it (filt_len = 0..3). Shorter pulses have no effect on position or flags.
- R8: Inputs are sampled once every 2^presc clocks (presc = 0..7). A pulse shorter than the filter window at that rate is rejected.
- R9: A rising edge of the filtered index copies position into idx_snap and raises flags bit 0. When idx_reload is 1, position is also loaded with init_val.
- R10: With max_reload = 1, an up step from max_count loads init_val and a down step from 0 loads max_count. Both raise flags bit 3.
- R11: Every counted step raises flags bit 6 (movement). A step that lands on cmp_val raises flags bit 2. A step whose direction differs from dir raises flags bit 5.
- R12: A rising edge of cap_strobe copies position into cap_snap and raises flags bit 4, cap_delay clocks after the edge is detected. When cap_delay is 0, the copy is made at once.
- R13: When sticky = 1, a flag stays set until a 1 is written to it through flag_clr. When sticky = 0, each flag is high for the one clock of its event. irq is the OR of flags AND irq_en.
- R14: While enable is 0, no samples are taken and phase activity does not change position. A pos_wr pulse loads pos_wdata into position at any time, taking priority over all other updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Enables sampling and counting |
| mul_sel | input | 2 | Count multiplication: 0 x1, 1 x2, 2 x4 (3 acts as x4) |
| swap_ab | input | 1 | Exchange the A and B phase inputs |
| filt_len | input | 2 | Filter length minus one, in samples |
| presc | input | 3 | Sample rate divider exponent |
| idx_reload | input | 1 | Reload the count on the index edge |
| max_reload | input | 1 | Reload on passing max_count or 0 |
| sticky | input | 1 | Flags hold until cleared |
| max_count | input | 32 | Count ceiling |
| init_val | input | 32 | Reload value |
| cmp_val | input | 32 | Compare value |
| cap_delay | input | 32 | Clocks from strobe edge to capture |
| pos_wr | input | 1 | Preset strobe for the count |
| pos_wdata | input | 32 | Preset value |
| flag_clr | input | 7 | Write-one-to-clear mask for flags |
| irq_en | input | 7 | Interrupt enable mask |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Encoder index (asynchronous) |
| cap_strobe | input | 1 | External capture request (asynchronous) |
| position | output | 32 | Current count |
| dir | output | 1 | 1 when the last step was up |
| idx_snap | output | 32 | Count at the last index edge |
| cap_snap | output | 32 | Count at the last capture |
| flags | output | 7 | Bits: 0 index, 1 phase error, 2 compare, 3 max, 4 capture, 5 direction change, 6 movement |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume that configuration inputs are held steady while the encoder moves. The prescaler check also assumes presc does not change in the cycle after a tick at the slowest rate. The bench changes mode, swap, filter and prescale only between scenarios, and exchanges the phases only while A equals B. The sticky-hold property assumes flag_clr is the only way a set flag is cleared. The bench holds each encoder state longer than the filter window at the chosen sample rate. Phase-error and glitch cases are produced on purpose, and only inside their own scenarios.

// File: rtl/qd_pkg.sv
package qd_pkg;
  localparam int NFLAGS    = 7;
  localparam int FLG_IDX   = 0;
  localparam int FLG_QERR  = 1;
  localparam int FLG_CMP   = 2;
  localparam int FLG_MAX   = 3;
  localparam int FLG_CAP   = 4;
  localparam int FLG_DIR   = 5;
  localparam int FLG_MOVE  = 6;

  typedef enum logic [1:0] {
    MUL_X1 = 2'd0,
    MUL_X2 = 2'd1,
    MUL_X4 = 2'd2
  } mul_e;
endpackage

// File: rtl/qd_prescale.sv
module qd_prescale #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int CW = (1 << PSC_W) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  // Low psc bits of the free-running counter all ones -> one tick per 2^psc
  assign mask = {CW{1'b1}} >> (CW - int'(psc));
  assign tick = en && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  // R8: at the slowest rate two ticks are never adjacent
  a_r8_slow_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && psc == '1) |=> (psc != '1 || !tick));
endmodule

// File: rtl/qd_filter.sv
module qd_filter #(
  parameter int N     = 3,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [LW-1:0] len,
  input  logic [N-1:0]  din,
  output logic [N-1:0]  dout
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [DEPTH-1:0] hist;
    logic [DEPTH-1:0] nh;
    logic             agree;

    assign nh = {hist[DEPTH-2:0], din[i]};

    always_comb begin
      agree = 1'b1;
      for (int k = 0; k < DEPTH; k++)
        if (k <= int'(len) && nh[k] != din[i]) agree = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hist    <= '0;
        dout[i] <= 1'b0;
      end else if (tick) begin
        hist <= nh;
        if (agree) dout[i] <= din[i];
      end
    end

    // R7: output moves only on a sample tick
    a_r7_filter_holds: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(dout[i]));
  end
endmodule

// File: rtl/qd_core.sv
module qd_core
  import qd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              swap,
  input  logic              sticky,
  input  logic              idx_reload,
  input  logic              max_reload,
  input  logic [W-1:0]      max_count,
  input  logic [W-1:0]      init_val,
  input  logic [W-1:0]      cmp_val,
  input  logic [W-1:0]      cap_delay,
  input  logic              pos_wr,
  input  logic [W-1:0]      pos_wdata,
  input  logic [NFLAGS-1:0] flag_clr,
  input  logic              fa,
  input  logic              fb,
  input  logic              fidx,
  input  logic              stb,
  output logic [W-1:0]      position,
  output logic              dir,
  output logic [W-1:0]      idx_snap,
  output logic [W-1:0]      cap_snap,
  output logic [NFLAGS-1:0] flags
);
  logic pfa, pfb, pidx, pstb;
  logic a, b, pa, pb, da, db;
  logic qerr, step, up, idx_ev, stb_ev, cap_fire, pending, dir_n;
  logic [W-1:0] pos_n, dcnt;
  logic [NFLAGS-1:0] ev, flags_n;

  assign a  = swap ? fb  : fa;
  assign b  = swap ? fa  : fb;
  assign pa = swap ? pfb : pfa;
  assign pb = swap ? pfa : pfb;
  assign da = a ^ pa;
  assign db = b ^ pb;
  assign qerr   = da & db;
  assign idx_ev = fidx & ~pidx;
  assign stb_ev = stb & ~pstb;
  assign cap_fire = (stb_ev && !pending && cap_delay == '0) ||
                    (pending && dcnt >= cap_delay);

  always_comb begin
    case (mul_e'(mode))
      MUL_X1:  begin step = da & a & ~db; up = ~b;    end
      MUL_X2:  begin step = da & ~db;     up = a ^ b; end
      default: begin step = da ^ db;      up = da ? (a ^ b) : ~(a ^ b); end
    endcase
  end

  always_comb begin
    pos_n = position;
    dir_n = dir;
    ev    = '0;
    if (step) begin
      dir_n = up;
      if (up) begin
        if (max_reload && position == max_count) begin
          pos_n = init_val; ev[FLG_MAX] = 1'b1;
        end else pos_n = position + 1'b1;
      end else begin
        if (max_reload && position == '0) begin
          pos_n = max_count; ev[FLG_MAX] = 1'b1;
        end else pos_n = position - 1'b1;
      end
      ev[FLG_MOVE] = 1'b1;
      ev[FLG_CMP]  = (pos_n == cmp_val);
      ev[FLG_DIR]  = (up != dir);
    end
    ev[FLG_QERR] = qerr;
    ev[FLG_CAP]  = cap_fire;
    if (idx_ev) begin
      ev[FLG_IDX] = 1'b1;
      if (idx_reload) pos_n = init_val;
    end
    if (pos_wr) pos_n = pos_wdata;
    flags_n = sticky ? ((flags & ~flag_clr) | ev) : ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {pfa, pfb, pidx, pstb} <= '0;
      position <= '0;
      dir      <= 1'b0;
      flags    <= '0;
      idx_snap <= '0;
      cap_snap <= '0;
      pending  <= 1'b0;
      dcnt     <= '0;
    end else begin
      {pfa, pfb, pidx, pstb} <= {fa, fb, fidx, stb};
      position <= pos_n;
      dir      <= dir_n;
      flags    <= flags_n;
      if (idx_ev)   idx_snap <= position;
      if (cap_fire) cap_snap <= position;
      if (pending) begin
        if (dcnt >= cap_delay) pending <= 1'b0;
        else                   dcnt <= dcnt + 1'b1;
      end else if (stb_ev && cap_delay != '0) begin
        pending <= 1'b1;
        dcnt    <= W'(1);
      end
    end
  end

  // R6: an illegal double transition never moves the count
  a_r6_qerr_no_count: assert property (@(posedge clk) disable iff (rst)
    (qerr && !pos_wr && !idx_ev) |=> position == $past(position));

  // R2: an ordinary step moves the count by exactly one
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    (step && !pos_wr && !idx_ev && !ev[FLG_MAX]) |=>
      (position == $past(position) + 1'b1 || position == $past(position) - 1'b1));

  // R13: in sticky mode an uncleared flag stays set
  a_r13_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (sticky && |(flags & ~flag_clr)) |=>
      ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));
endmodule

// File: rtl/quad_counter.sv
module quad_counter
  import qd_pkg::*;
#(
  parameter int W     = 32,
  parameter int PSC_W = 3,
  parameter int FDEP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        mul_sel,
  input  logic              swap_ab,
  input  logic [1:0]        filt_len,
  input  logic [PSC_W-1:0]  presc,
  input  logic              idx_reload,
  input  logic              max_reload,
  input  logic              sticky,
  input  logic [W-1:0]      max_count,
  input  logic [W-1:0]      init_val,
  input  logic [W-1:0]      cmp_val,
  input  logic [W-1:0]      cap_delay,
  input  logic              pos_wr,
  input  logic [W-1:0]      pos_wdata,
  input  logic [NFLAGS-1:0] flag_clr,
  input  logic [NFLAGS-1:0] irq_en,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              cap_strobe,
  output logic [W-1:0]      position,
  output logic              dir,
  output logic [W-1:0]      idx_snap,
  output logic [W-1:0]      cap_snap,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  localparam int NS = 4;

  logic [NS-1:0] s1, s2;
  logic [2:0]    filt_out;
  logic          tick;

  // Two-stage synchronizer: {strobe, index, b, a}
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {cap_strobe, enc_idx, enc_b, enc_a};
      s2 <= s1;
    end
  end

  qd_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .en(enable), .psc(presc), .tick(tick)
  );

  qd_filter #(.N(3), .DEPTH(FDEP)) u_filt (
    .clk(clk), .rst(rst), .tick(tick), .len(filt_len),
    .din(s2[2:0]), .dout(filt_out)
  );

  qd_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .mode(mul_sel), .swap(swap_ab), .sticky(sticky),
    .idx_reload(idx_reload), .max_reload(max_reload), .max_count(max_count),
    .init_val(init_val), .cmp_val(cmp_val), .cap_delay(cap_delay),
    .pos_wr(pos_wr), .pos_wdata(pos_wdata), .flag_clr(flag_clr),
    .fa(filt_out[0]), .fb(filt_out[1]), .fidx(filt_out[2]), .stb(s2[3]),
    .position(position), .dir(dir), .idx_snap(idx_snap),
    .cap_snap(cap_snap), .flags(flags)
  );

  assign irq = |(flags & irq_en);
endmodule

// File: tb/quad_counter_test.sv
module quad_counter_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, enable, swap_ab, idx_reload, max_reload, sticky, pos_wr;
  logic [1:0]  mul_sel, filt_len;
  logic [2:0]  presc;
  logic [31:0] max_count, init_val, cmp_val, cap_delay, pos_wdata;
  logic [6:0]  flag_clr, irq_en;
  logic        enc_a, enc_b, enc_idx, cap_strobe;
  logic [31:0] position, idx_snap, cap_snap;
  logic        dir, irq;
  logic [6:0]  flags;

  int vectors = 0;
  int errors  = 0;
  int phase   = 0;
  int hold    = 12;

  quad_counter uut (
    .clk(clk), .rst(rst), .enable(enable), .mul_sel(mul_sel), .swap_ab(swap_ab),
    .filt_len(filt_len), .presc(presc), .idx_reload(idx_reload),
    .max_reload(max_reload), .sticky(sticky), .max_count(max_count),
    .init_val(init_val), .cmp_val(cmp_val), .cap_delay(cap_delay),
    .pos_wr(pos_wr), .pos_wdata(pos_wdata), .flag_clr(flag_clr), .irq_en(irq_en),
    .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .cap_strobe(cap_strobe),
    .position(position), .dir(dir), .idx_snap(idx_snap), .cap_snap(cap_snap),
    .flags(flags), .irq(irq)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Gray phases as {a,b}: 0:00 1:10 2:11 3:01
  task automatic drive_phase();
    case (phase)
      0: {enc_a, enc_b} = 2'b00;
      1: {enc_a, enc_b} = 2'b10;
      2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b01;
    endcase
  endtask

  task automatic step(input int d, input int n);
    for (int i = 0; i < n; i++) begin
      phase = (phase + d + 4) % 4;
      drive_phase();
      wait_clk(hold);
    end
  endtask

  task automatic preset(input logic [31:0] v);
    pos_wdata = v; pos_wr = 1'b1;
    wait_clk(1);
    pos_wr = 1'b0;
    wait_clk(1);
  endtask

  task automatic clear_flags();
    flag_clr = 7'h7F;
    wait_clk(1);
    flag_clr = 7'h00;
    wait_clk(1);
  endtask

  task automatic t_reset();
    check("R1 position", position, 0);
    check("R1 dir", {31'd0, dir}, 0);
    check("R1 flags", {25'd0, flags}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 snaps", idx_snap | cap_snap, 0);
  endtask

  task automatic t_x4();
    mul_sel = 2'd2;
    step(1, 8);
    check("R2 x4 forward", position, 8);
    check("R2 dir up", {31'd0, dir}, 1);
    step(-1, 3);
    check("R2 x4 reverse", position, 5);
    check("R2 dir down", {31'd0, dir}, 0);
  endtask

  task automatic t_x2();
    mul_sel = 2'd1;
    preset(0);
    step(1, 8);
    check("R3 x2 count", position, 4);
  endtask

  task automatic t_x1();
    mul_sel = 2'd0;
    preset(0);
    step(1, 8);
    check("R4 x1 forward", position, 2);
    step(-1, 8);
    check("R4 x1 reverse", position, 0);
  endtask

  task automatic t_swap();
    mul_sel = 2'd2;
    step(-1, 1);                 // back to phase 0, where a equals b
    preset(0);
    swap_ab = 1'b1;
    wait_clk(4);
    step(1, 4);
    check("R5 swapped forward", position, 32'hFFFF_FFFC);
    swap_ab = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_qerr();
    preset(20);
    clear_flags();
    phase = (phase + 2) % 4;
    drive_phase();
    wait_clk(hold);
    check("R6 qerr flag", {31'd0, flags[1]}, 1);
    check("R6 count held", position, 20);
  endtask

  task automatic t_filter();
    filt_len = 2'd3;
    preset(30);
    wait_clk(hold);
    clear_flags();
    enc_a = ~enc_a; wait_clk(3); enc_a = ~enc_a; wait_clk(hold);
    check("R7 short glitch rejected", {25'd0, flags}, 0);
    check("R7 count kept", position, 30);
    filt_len = 2'd0;
    enc_a = ~enc_a; wait_clk(3); enc_a = ~enc_a; wait_clk(hold);
    check("R7 unfiltered glitch seen", {31'd0, flags[6]}, 1);
  endtask

  task automatic t_presc();
    presc = 3'd5; filt_len = 2'd3;
    preset(0);
    clear_flags();
    enc_a = ~enc_a; wait_clk(60); enc_a = ~enc_a; wait_clk(200);
    check("R8 slow sampling rejects pulse", {31'd0, flags[6]}, 0);
    hold = 200;
    step(1, 4);
    check("R8 slow sampling counts", position, 4);
    hold = 12; presc = 3'd0; filt_len = 2'd0;
    wait_clk(hold);
  endtask

  task automatic t_index();
    init_val = 7; idx_reload = 1'b1;
    preset(100);
    clear_flags();
    enc_idx = 1'b1; wait_clk(hold); enc_idx = 1'b0; wait_clk(hold);
    check("R9 index snapshot", idx_snap, 100);
    check("R9 index reload", position, 7);
    check("R9 index flag", {31'd0, flags[0]}, 1);
    idx_reload = 1'b0;
    preset(50);
    enc_idx = 1'b1; wait_clk(hold); enc_idx = 1'b0; wait_clk(hold);
    check("R9 snapshot no reload", idx_snap, 50);
    check("R9 count kept", position, 50);
  endtask

  task automatic t_max();
    max_count = 5; init_val = 2; max_reload = 1'b1;
    preset(4);
    clear_flags();
    step(1, 1);
    check("R10 below max", position, 5);
    check("R10 no flag yet", {31'd0, flags[3]}, 0);
    step(1, 1);
    check("R10 up wrap", position, 2);
    check("R10 max flag", {31'd0, flags[3]}, 1);
    preset(0);
    step(-1, 1);
    check("R10 down wrap", position, 5);
    max_reload = 1'b0; max_count = 32'hFFFF_FFFF;
  endtask

  task automatic t_compare();
    cmp_val = 3;
    preset(1);
    clear_flags();
    step(1, 1);
    check("R11 no compare at 2", {31'd0, flags[2]}, 0);
    check("R11 move flag", {31'd0, flags[6]}, 1);
    step(1, 1);
    check("R11 compare at 3", {31'd0, flags[2]}, 1);
    clear_flags();
    step(-1, 1);
    check("R11 direction flag", {31'd0, flags[5]}, 1);
    cmp_val = 32'h1000;
  endtask

  task automatic t_capture();
    cap_delay = 20;
    preset(77);
    clear_flags();
    cap_strobe = 1'b1;
    wait_clk(8);
    check("R12 capture waits", {31'd0, flags[4]}, 0);
    wait_clk(30);
    check("R12 capture flag", {31'd0, flags[4]}, 1);
    check("R12 capture value", cap_snap, 77);
    cap_strobe = 1'b0;
    cap_delay = 0;
    wait_clk(4);
    preset(88);
    cap_strobe = 1'b1; wait_clk(6); cap_strobe = 1'b0; wait_clk(2);
    check("R12 zero delay capture", cap_snap, 88);
  endtask

  task automatic t_irq_sticky();
    clear_flags();
    irq_en = 7'h40;
    step(1, 1);
    check("R13 irq on enabled flag", {31'd0, irq}, 1);
    irq_en = 7'h00; #1;
    check("R13 irq masked", {31'd0, irq}, 0);
    irq_en = 7'h40;
    clear_flags();
    check("R13 cleared flags", {25'd0, flags}, 0);
    check("R13 irq after clear", {31'd0, irq}, 0);
    sticky = 1'b0;
    step(1, 1);
    check("R13 non-sticky pulse gone", {25'd0, flags}, 0);
    sticky = 1'b1; irq_en = 7'h00;
  endtask

  task automatic t_enable();
    preset(40);
    enable = 1'b0;
    step(1, 4);
    check("R14 disabled no count", position, 40);
    preset(123);
    check("R14 preset while disabled", position, 123);
    enable = 1'b1;
    wait_clk(hold);
    check("R14 re-enable", position, 123);
  endtask

  initial begin
    rst = 1'b1; enable = 1'b1; mul_sel = 2'd2; swap_ab = 1'b0; filt_len = 2'd0;
    presc = 3'd0; idx_reload = 1'b0; max_reload = 1'b0; sticky = 1'b1;
    max_count = 32'hFFFF_FFFF; init_val = 0; cmp_val = 32'h1000; cap_delay = 0;
    pos_wr = 1'b0; pos_wdata = 0; flag_clr = 0; irq_en = 0;
    enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b0; cap_strobe = 1'b0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_x4();
    t_x2();
    t_x1();
    t_swap();
    t_qerr();
    t_filter();
    t_presc();
    t_index();
    t_max();
    t_compare();
    t_capture();
    t_irq_sticky();
    t_enable();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule